// File: doc/BRIEF.md
# Power-Gating Interval Timer

This block decides when a downstream processor gets power. It drives an active-low gate output: low turns the external power switch on, high turns it off. Its interval counter advances on a slow reference tick enable. In periodic mode, each new interval pulls the drive low. In single-shot mode, only the first interval after startup does. After that, a new pulse needs a manual trigger.

A pulse ends in one of two ways. The processor can end it early with a rising edge on its DONE line, which is synchronised inside the block. Otherwise the drive is forced high for the last `GUARD_TICKS` ticks of the interval. A manual trigger is accepted only while the drive is high. The trigger then holds the drive low and keeps the counter cleared for as long as the trigger is held. Releasing the trigger starts a fresh interval.

Nothing happens while the startup configuration phase is running. The interval length must be larger than the guard length.

Top module: `pgt_gate_timer`

## Requirements
- R1: While the configuration-busy input is high after reset, `drv_no` stays high and `restart_o` stays low. Within 2 clock cycles after configuration-busy goes low, `drv_no` goes low.
- R2: In periodic mode (`periodic_i` = 1), successive falling edges of `drv_no` are exactly `interval_i` ticks apart when no manual trigger is used.
- R3: If no DONE edge arrives, `drv_no` stays low for `interval_i - GUARD_TICKS` ticks (within one tick). It is then high for the rest of the interval.
- R4: A low-to-high transition on `done_i` forces `drv_no` high within 4 clock cycles. A `done_i` level that is still high when a new interval starts has no effect on that interval. Only the first DONE edge in an interval is acted on.
- R5: In single-shot mode (`periodic_i` = 0), exactly one drive pulse follows configuration. No further pulse occurs until a manual trigger is accepted.
- R6: A rising edge of `man_i` while `drv_no` is low is ignored. The drive stays low and the pulse timing is unchanged.
- R7: A rising edge of `man_i` while `drv_no` is high pulls `drv_no` low within 2 clock cycles. `drv_no` then stays low for as long as `man_i` is held, even longer than the interval, and DONE edges are ignored. After `man_i` falls, a fresh interval runs from zero.
- R8: `restart_o` is a one-cycle pulse that coincides with the drive going low at each interval start. Interval starts are: end of configuration, a periodic wrap, and release of an accepted manual trigger. There is no pulse while a manual trigger is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow reference tick enable, one cycle wide |
| cfg_busy_i | input | 1 | High while startup interval configuration runs |
| periodic_i | input | 1 | 1 = periodic mode, 0 = single-shot mode (static) |
| interval_i | input | CNT_W | Interval length in ticks, larger than GUARD_TICKS |
| done_i | input | 1 | Asynchronous DONE from the processor; rising edge counts |
| man_i | input | 1 | Debounced manual trigger level |
| drv_no | output | 1 | Active-low gate drive |
| restart_o | output | 1 | One-cycle pulse at each interval start |

## Verification
Periodic runs with no DONE fix the guard-limited pulse width and the exact falling-edge spacing. A DONE pulse early in an interval shows the early release. A DONE level held across a wrap shows that only edges count. Single-shot runs, before and after a manual trigger, separate the one-shot behaviour from periodic repetition. A manual trigger during a low pulse is compared with one accepted while the drive is high. This shows the ignore rule, the held-low extension that blocks DONE, and the restart timing after release.

// File: rtl/pgt_pkg.sv
package pgt_pkg;
  typedef enum logic [2:0] {
    ST_CFG,
    ST_ON,
    ST_OFF,
    ST_STOP,
    ST_MAN
  } pgt_state_e;
endpackage

// File: rtl/pgt_done_sync.sv
module pgt_done_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [2:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[1:0], async_i};
  end

  // sr_q[1] is the second synchroniser stage, sr_q[2] its delayed copy
  assign rise_o = sr_q[1] & ~sr_q[2];
endmodule

// File: rtl/pgt_interval_cnt.sv
module pgt_interval_cnt #(
  parameter int CNT_W       = 16,
  parameter int GUARD_TICKS = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] interval_i,
  output logic             guard_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] GUARD_C = CNT_W'(GUARD_TICKS);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_c;
  logic [CNT_W-1:0] guard_start_c;

  assign last_c        = interval_i - ONE_C;
  assign guard_start_c = interval_i - GUARD_C;
  assign wrap_o        = run_i & tick_i & (cnt_q >= last_c);
  assign guard_o       = run_i & (cnt_q >= guard_start_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (run_i && tick_i)  cnt_q <= (cnt_q >= last_c) ? '0 : cnt_q + ONE_C;
  end

  // R2: count never leaves the programmed interval while running
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i) |-> (cnt_q < interval_i));
endmodule

// File: rtl/pgt_drive_fsm.sv
module pgt_drive_fsm
  import pgt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_busy_i,
  input  logic periodic_i,
  input  logic guard_i,
  input  logic wrap_i,
  input  logic done_rise_i,
  input  logic man_i,
  input  logic man_rise_i,
  output logic run_o,
  output logic clr_o,
  output logic drv_no,
  output logic restart_o
);
  pgt_state_e st_q, st_d;
  logic start;
  logic taken_q;
  logic done_ev;
  logic drv_q;
  logic restart_q;

  // first DONE edge of the interval, never while manual is held
  assign done_ev = done_rise_i & ~man_i & ~taken_q;

  always_comb begin
    st_d  = st_q;
    start = 1'b0;
    unique case (st_q)
      ST_CFG: if (!cfg_busy_i) begin st_d = ST_ON; start = 1'b1; end
      ST_ON:  if (done_ev || guard_i) st_d = ST_OFF;
      ST_OFF: begin
        if (man_rise_i) st_d = ST_MAN;
        else if (wrap_i) begin
          if (periodic_i) begin st_d = ST_ON; start = 1'b1; end
          else            st_d = ST_STOP;
        end
      end
      ST_STOP: if (man_rise_i) st_d = ST_MAN;
      ST_MAN:  if (!man_i) begin st_d = ST_ON; start = 1'b1; end
      default: st_d = ST_CFG;
    endcase
  end

  assign run_o = (st_q == ST_ON) || (st_q == ST_OFF);
  assign clr_o = start | ~run_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_CFG;
      taken_q   <= 1'b0;
      drv_q     <= 1'b1;
      restart_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      drv_q     <= ~((st_d == ST_ON) || (st_d == ST_MAN));
      restart_q <= start;
      if (start)                                 taken_q <= 1'b0;
      else if (done_rise_i && !man_i && run_o)   taken_q <= 1'b1;
    end
  end

  assign drv_no    = drv_q;
  assign restart_o = restart_q;

  // R1: drive held off during configuration
  p_cfg_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CFG && cfg_busy_i) |=> (drv_no && !restart_o));
  // R3: guard window forces the switch off
  p_guard_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ON && guard_i) |=> drv_no);
  // R4: accepted DONE ends the pulse
  p_done_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ON && done_ev) |=> drv_no);
  // R5: single-shot wrap issues no new pulse
  p_oneshot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OFF && wrap_i && !periodic_i && !man_rise_i) |=> (drv_no && !restart_o));
  // R6: trigger during low pulse changes nothing
  p_man_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ON && man_rise_i && !guard_i && !done_ev) |=> !drv_no);
  // R7: held trigger keeps drive low
  p_man_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MAN && man_i) |=> (!drv_no && !restart_o));
  // R8: restart pulse only with drive low
  p_restart_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> !drv_no);
endmodule

// File: rtl/pgt_gate_timer.sv
module pgt_gate_timer #(
  parameter int CNT_W       = 16,
  parameter int GUARD_TICKS = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cfg_busy_i,
  input  logic             periodic_i,
  input  logic [CNT_W-1:0] interval_i,
  input  logic             done_i,
  input  logic             man_i,
  output logic             drv_no,
  output logic             restart_o
);
  logic done_rise;
  logic man_q;
  logic man_rise;
  logic run;
  logic clr;
  logic guard;
  logic wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) man_q <= 1'b0;
    else         man_q <= man_i;
  end
  assign man_rise = man_i & ~man_q;

  pgt_done_sync u_done_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (done_i),
    .rise_o  (done_rise)
  );

  pgt_interval_cnt #(
    .CNT_W       (CNT_W),
    .GUARD_TICKS (GUARD_TICKS)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (run),
    .clr_i      (clr),
    .interval_i (interval_i),
    .guard_o    (guard),
    .wrap_o     (wrap)
  );

  pgt_drive_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_busy_i  (cfg_busy_i),
    .periodic_i  (periodic_i),
    .guard_i     (guard),
    .wrap_i      (wrap),
    .done_rise_i (done_rise),
    .man_i       (man_i),
    .man_rise_i  (man_rise),
    .run_o       (run),
    .clr_o       (clr),
    .drv_no      (drv_no),
    .restart_o   (restart_o)
  );
endmodule

// File: tb/pgt_gate_timer_bench.sv
`timescale 1ns/1ps
module pgt_gate_timer_bench;
  localparam int CW  = 16;
  localparam int G   = 3;
  localparam int N   = 10;
  localparam int DIV = 4;
  localparam int LOW_NOM = (N - G) * DIV;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          cfg_busy = 1'b1;
  logic          periodic = 1'b1;
  logic [CW-1:0] interval = CW'(N);
  logic          done = 1'b0;
  logic          man = 1'b0;
  logic          drv_n;
  logic          restart;

  pgt_gate_timer #(.CNT_W(CW), .GUARD_TICKS(G)) u_pgt_gate_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cfg_busy_i(cfg_busy),
    .periodic_i(periodic), .interval_i(interval), .done_i(done),
    .man_i(man), .drv_no(drv_n), .restart_o(restart)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tdiv = 0;
  int falls = 0, rises = 0, restarts = 0;
  int fall_last = 0, fall_prev = 0, rise_last = 0;
  logic drv_prev = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tdiv = (tdiv == DIV - 1) ? 0 : tdiv + 1;
    tick = (tdiv == 0);
  end

  always @(negedge clk) begin
    if (drv_prev && !drv_n) begin falls++; fall_prev = fall_last; fall_last = cyc; end
    if (!drv_prev && drv_n) begin rises++; rise_last = cyc; end
    if (restart) restarts++;
    drv_prev = drv_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_falls(input int target);
    for (int t = 0; t < 3000 && falls < target; t++) @(negedge clk);
  endtask

  task automatic wait_rises(input int target);
    for (int t = 0; t < 3000 && rises < target; t++) @(negedge clk);
  endtask

  task automatic do_reset(input bit per);
    @(negedge clk);
    rst_n = 1'b0; cfg_busy = 1'b1; periodic = per; interval = CW'(N);
    done = 1'b0; man = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic start_cfg();
    int f0;
    f0 = falls;
    cfg_busy = 1'b0;
    wait_falls(f0 + 1);
  endtask

  task automatic t_reset();
    int r0;
    do_reset(1'b1);
    chk(drv_n == 1'b1, "R1 drive high in config", drv_n, 1);
    chk(restart == 1'b0, "R1 no restart in config", restart, 0);
    repeat (40) @(negedge clk);
    chk(drv_n == 1'b1, "R1 drive held during long config", drv_n, 1);
    r0 = restarts;
    cfg_busy = 1'b0;
    repeat (2) @(negedge clk);
    chk(drv_n == 1'b0, "R1 drive low after config", drv_n, 0);
    chk(restarts == r0 + 1, "R8 restart at config end", restarts - r0, 1);
  endtask

  task automatic t_periodic();
    int f0, r0, low;
    do_reset(1'b1);
    start_cfg();
    f0 = falls; r0 = restarts;
    wait_rises(rises + 1);
    low = rise_last - fall_last;
    chk(low >= LOW_NOM - 3 && low <= LOW_NOM + 2, "R3 guard-limited low width", low, LOW_NOM);
    wait_falls(f0 + 2);
    chk(fall_last - fall_prev == N * DIV, "R2 periodic spacing", fall_last - fall_prev, N * DIV);
    low = 0;
    wait_rises(rises + 1);
    low = rise_last - fall_last;
    chk(low >= LOW_NOM - 3 && low <= LOW_NOM + 2, "R3 steady low width", low, LOW_NOM);
    chk(restarts - r0 == falls - f0, "R8 restart per interval", restarts - r0, falls - f0);
  endtask

  task automatic t_done();
    int f0;
    do_reset(1'b1);
    start_cfg();
    repeat (5) @(negedge clk);
    done = 1'b1;
    repeat (2) @(negedge clk);
    done = 1'b0;
    repeat (5) @(negedge clk);
    chk(drv_n == 1'b1, "R4 DONE edge ends pulse", drv_n, 1);
    chk(rise_last - fall_last <= 12, "R4 early release width", rise_last - fall_last, 9);
    // DONE level held across the next interval start
    done = 1'b1;
    f0 = falls;
    wait_falls(f0 + 1);
    repeat (15) @(negedge clk);
    chk(drv_n == 1'b0, "R4 held DONE level ignored", drv_n, 0);
    done = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    repeat (6) @(negedge clk);
    chk(drv_n == 1'b1, "R4 new edge accepted next interval", drv_n, 1);
    done = 1'b0;
  endtask

  task automatic t_oneshot();
    int f0;
    do_reset(1'b0);
    start_cfg();
    wait_rises(rises + 1);
    chk(rise_last - fall_last >= LOW_NOM - 3 && rise_last - fall_last <= LOW_NOM + 2,
        "R5 single pulse width", rise_last - fall_last, LOW_NOM);
    f0 = falls;
    repeat (4 * N * DIV) @(negedge clk);
    chk(falls == f0, "R5 no repeat in single-shot", falls - f0, 0);
    chk(drv_n == 1'b1, "R5 drive idle high", drv_n, 1);
  endtask

  task automatic t_man_ignored();
    int f0;
    do_reset(1'b1);
    start_cfg();
    f0 = falls;
    wait_falls(f0 + 1);
    repeat (4) @(negedge clk);
    man = 1'b1;
    repeat (6) @(negedge clk);
    man = 1'b0;
    repeat (2) @(negedge clk);
    chk(drv_n == 1'b0, "R6 drive unchanged by trigger", drv_n, 0);
    wait_rises(rises + 1);
    chk(rise_last - fall_last == LOW_NOM + 1, "R6 low width unchanged", rise_last - fall_last, LOW_NOM + 1);
    wait_falls(f0 + 2);
    chk(fall_last - fall_prev == N * DIV, "R6 period unchanged", fall_last - fall_prev, N * DIV);
  endtask

  task automatic t_manual();
    int r0, rel, f0;
    do_reset(1'b0);
    start_cfg();
    wait_rises(rises + 1);
    repeat (10) @(negedge clk);
    r0 = restarts;
    man = 1'b1;
    repeat (2) @(negedge clk);
    chk(drv_n == 1'b0, "R7 accepted trigger drives low", drv_n, 0);
    repeat (100) @(negedge clk);
    chk(drv_n == 1'b0, "R7 held beyond interval", drv_n, 0);
    done = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b0;
    repeat (6) @(negedge clk);
    chk(drv_n == 1'b0, "R7 DONE ignored while held", drv_n, 0);
    chk(restarts == r0, "R8 no restart while held", restarts - r0, 0);
    man = 1'b0;
    rel = cyc;
    repeat (3) @(negedge clk);
    chk(restarts == r0 + 1, "R8 restart on release", restarts - r0, 1);
    wait_rises(rises + 1);
    chk(rise_last - rel >= LOW_NOM - 4 && rise_last - rel <= LOW_NOM + 4,
        "R7 fresh interval after release", rise_last - rel, LOW_NOM);
    f0 = falls;
    repeat (3 * N * DIV) @(negedge clk);
    chk(falls == f0, "R5 single-shot after manual pulse", falls - f0, 0);
  endtask

  initial begin
    t_reset();
    t_periodic();
    t_done();
    t_oneshot();
    t_man_ignored();
    t_manual();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule